// File: doc/BRIEF.md
# Macroblock Decoder Command and Status Front End

This block sits between a processor bus and a macroblock decoding datapath. Software writes a 32-bit command word or a control word. It reads back the control state, a packed bit-pointer word, the last command result and a top-of-stream word. The block decodes the opcode in the command word. Two commands need no stream data, and the block finishes them on the spot. Every other command is handed to the worker datapath through a start pulse and a held command word. The block then stays busy until the worker reports completion.

The worker engines, the FIFOs and the DMA lie outside this block. They appear only as plain status pins: a done strobe with result values, a live FIFO occupancy, a fill pointer, status-set strobes and a bit-pointer advance. Every interface is plain control or status wiring. Nothing streams through the block, so no port carries back-pressure. All bus accesses complete in a single cycle, and the read data depends only on the read address and the current state.

Top module: `mbdec_cmd_regs`

## Requirements
- R1: Only address bits 7:0 select a register for both writes and reads, so the register set repeats every 0x100 bytes. The offsets are: 0x00 command (write) and result data (read), 0x10 control, 0x20 bit pointer, 0x30 top word.
- R2: A command write with a defined opcode clears the end-of-data status (control bit 14) and the start-code status (control bit 15). The clear takes priority over a set strobe in the same cycle.
- R3: Opcode 0 (flush) loads the bit pointer from word bits 6:0 and pulses the FIFO clear output. Opcode 9 (thresholds) loads the low threshold from bits 7:0 and the high threshold from bits 23:16. Both commands pulse the interrupt and leave busy at 0.
- R4: Opcodes 1 to 5 advance the 7-bit bit pointer by command bits 5:0, modulo 128, and no other opcode moves it. Without a command, a worker advance strobe adds its amount to the pointer.
- R5: Opcodes 1 to 8 set busy (control bit 31), expose the word on the current-command output and pulse the worker start.
- R6: A done strobe while busy clears busy, sets the current command to all ones, pulses the interrupt for exactly one cycle, and latches the result data, the top word and the coded block pattern.
- R7: A control write places bits 23:18 in the mode field and bits 17:16 in the precision field. Precision code 3 is stored as 1.
- R8: A control write with bit 30 set is a soft reset. It clears busy, the current command (to all ones), the bit pointer, the top word, the coded block pattern and both status flags, and it pulses the FIFO clear output.
- R9: The bit-pointer word read returns the pointer in bits 6:0, the input FIFO count in bits 15:8 and the fill pointer in bits 17:16.
- R10: The control word read returns the live FIFO count in bits 7:0 and the latched coded block pattern in bits 13:8.
- R11: Opcodes 10 to 15 are ignored. They leave busy, the interrupt, the bit pointer and the status flags unchanged.
- R12: A command write while busy replaces the current command. A done strobe in the same cycle as a command write is discarded.
- R13: A done strobe while idle has no effect, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data for rd_addr |
| work_start | output | 1 | One-cycle start pulse to the worker |
| cur_cmd | output | 32 | Current command word, all ones when idle |
| busy | output | 1 | Command in progress |
| irq | output | 1 | One-cycle completion interrupt |
| work_done | input | 1 | Worker completion strobe |
| work_data | input | 32 | Worker result data |
| work_top | input | 32 | Worker top-of-stream word |
| work_cbp | input | 6 | Worker coded block pattern |
| ecd_set | input | 1 | Sets end-of-data status |
| scd_set | input | 1 | Sets start-code status |
| bp_adv_en | input | 1 | Worker bit-pointer advance strobe |
| bp_adv_amt | input | 7 | Worker advance amount |
| fifo_count | input | IFC_W | Live input FIFO occupancy |
| fill_ptr | input | 2 | Fill pointer, 0 to 2 |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| thr_lo | output | 8 | Low threshold |
| thr_hi | output | 8 | High threshold |
| prec | output | 2 | Intra DC precision field |
| mode | output | 6 | Mode field |

## Verification
Two events can fall in the same cycle: a new command write and the completion strobe of the command already running. The bench provokes this by raising the done strobe in the same cycle as the write of a third busy command. It then checks that busy stays set, that the new word is current, that no interrupt is counted and that the result registers are untouched. A second collision pairs a thresholds command with the status-set strobes. The judgement is that both status bits read back clear.

// File: rtl/mbdec_pkg.sv
package mbdec_pkg;
  localparam int WORD_W  = 32;
  localparam int BP_W    = 7;
  localparam int SKIP_W  = 6;
  localparam int CBP_W   = 6;
  localparam int THR_W   = 8;
  localparam int OP_W    = 4;
  localparam int OFS_W   = 8;

  localparam logic [OFS_W-1:0] OFS_DATA = 8'h00;
  localparam logic [OFS_W-1:0] OFS_CTRL = 8'h10;
  localparam logic [OFS_W-1:0] OFS_BPTR = 8'h20;
  localparam logic [OFS_W-1:0] OFS_TOP  = 8'h30;

  localparam int SRST_BIT = 30;

  typedef enum logic [OP_W-1:0] {
    OP_FLUSH  = 4'd0,
    OP_INTRA  = 4'd1,
    OP_BLOCK  = 4'd2,
    OP_VLD    = 4'd3,
    OP_FLD    = 4'd4,
    OP_QMAT   = 4'd5,
    OP_CLUT   = 4'd6,
    OP_YCC    = 4'd7,
    OP_PACKC  = 4'd8,
    OP_THRESH = 4'd9
  } op_e;

  typedef struct packed {
    logic valid;
    logic inline_op;
    logic skip;
    logic flush;
    logic thresh;
  } dec_t;
endpackage

// File: rtl/mbdec_cmd_decode.sv
module mbdec_cmd_decode
  import mbdec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output dec_t            dec
);
  always_comb begin
    dec = '0;
    case (op)
      OP_FLUSH:  begin dec.valid = 1'b1; dec.inline_op = 1'b1; dec.flush = 1'b1; end
      OP_THRESH: begin dec.valid = 1'b1; dec.inline_op = 1'b1; dec.thresh = 1'b1; end
      OP_INTRA, OP_BLOCK, OP_VLD, OP_FLD, OP_QMAT:
                 begin dec.valid = 1'b1; dec.skip = 1'b1; end
      OP_CLUT, OP_YCC, OP_PACKC:
                 dec.valid = 1'b1;
      default:   dec = '0;
    endcase
  end
endmodule

// File: rtl/mbdec_bitptr.sv
module mbdec_bitptr
  import mbdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              load,
  input  logic [BP_W-1:0]   load_val,
  input  logic              skip,
  input  logic [SKIP_W-1:0] skip_amt,
  input  logic              adv,
  input  logic [BP_W-1:0]   adv_amt,
  output logic [BP_W-1:0]   bp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bp <= '0;
    else if (srst)  bp <= '0;
    else if (load)  bp <= load_val;
    else if (skip)  bp <= bp + BP_W'(skip_amt);
    else if (adv)   bp <= bp + adv_amt;
  end

  AST_SKIP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (skip && !srst && !load) |=> (bp == $past(bp + BP_W'(skip_amt)))); // R4
  AST_SRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (bp == '0)); // R8
  AST_FLUSH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !srst) |=> (bp == $past(load_val))); // R3
endmodule

// File: rtl/mbdec_ctrl_reg.sv
module mbdec_ctrl_reg
  import mbdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [5:0] wr_mode,
  input  logic [1:0] wr_prec,
  input  logic       srst,
  input  logic       cmd_clr,
  input  logic       ecd_set,
  input  logic       scd_set,
  output logic [5:0] mode,
  output logic [1:0] prec,
  output logic       ecd,
  output logic       scd
);
  logic [1:0] prec_clean;
  assign prec_clean = (wr_prec == 2'd3) ? 2'd1 : wr_prec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      prec <= '0;
    end else if (ctrl_we) begin
      mode <= wr_mode;
      prec <= prec_clean;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecd <= 1'b0;
      scd <= 1'b0;
    end else if (srst || cmd_clr) begin
      ecd <= 1'b0;
      scd <= 1'b0;
    end else begin
      if (ecd_set) ecd <= 1'b1;
      if (scd_set) scd <= 1'b1;
    end
  end

  AST_PREC_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wr_prec == 2'd3) |=> (prec == 2'd1)); // R7
  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> (!ecd && !scd)); // R2
endmodule

// File: rtl/mbdec_cmd_regs.sv
module mbdec_cmd_regs
  import mbdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IFC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              work_start,
  output logic [31:0]       cur_cmd,
  output logic              busy,
  output logic              irq,
  input  logic              work_done,
  input  logic [31:0]       work_data,
  input  logic [31:0]       work_top,
  input  logic [5:0]        work_cbp,
  input  logic              ecd_set,
  input  logic              scd_set,
  input  logic              bp_adv_en,
  input  logic [6:0]        bp_adv_amt,
  input  logic [IFC_W-1:0]  fifo_count,
  input  logic [1:0]        fill_ptr,
  output logic              fifo_clr,
  output logic [7:0]        thr_lo,
  output logic [7:0]        thr_hi,
  output logic [1:0]        prec,
  output logic [5:0]        mode
);
  localparam logic [WORD_W-1:0] NO_CMD = '1;

  logic [OFS_W-1:0] wofs, rofs;
  logic             cmd_we, ctrl_we, srst, cmd_go;
  dec_t             dec;
  logic             ecd, scd;
  logic [BP_W-1:0]  bp;
  logic [WORD_W-1:0] data_q, top_q;
  logic [CBP_W-1:0]  cbp_q;
  logic              unused_addr_hi;

  assign wofs    = wr_addr[OFS_W-1:0];
  assign rofs    = rd_addr[OFS_W-1:0];
  assign unused_addr_hi = ^{wr_addr[ADDR_W-1:OFS_W], rd_addr[ADDR_W-1:OFS_W]};
  assign cmd_we  = wr_en && (wofs == OFS_DATA);
  assign ctrl_we = wr_en && (wofs == OFS_CTRL);
  assign srst    = ctrl_we && wr_data[SRST_BIT];

  mbdec_cmd_decode u_dec (
    .op  (wr_data[WORD_W-1 -: OP_W]),
    .dec (dec)
  );

  assign cmd_go = cmd_we && dec.valid;

  mbdec_bitptr u_bp (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (srst),
    .load     (cmd_go && dec.flush),
    .load_val (wr_data[BP_W-1:0]),
    .skip     (cmd_go && dec.skip),
    .skip_amt (wr_data[SKIP_W-1:0]),
    .adv      (bp_adv_en),
    .adv_amt  (bp_adv_amt),
    .bp       (bp)
  );

  mbdec_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_we (ctrl_we),
    .wr_mode (wr_data[23:18]),
    .wr_prec (wr_data[17:16]),
    .srst    (srst),
    .cmd_clr (cmd_go),
    .ecd_set (ecd_set),
    .scd_set (scd_set),
    .mode    (mode),
    .prec    (prec),
    .ecd     (ecd),
    .scd     (scd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cur_cmd <= NO_CMD; irq <= 1'b0; work_start <= 1'b0;
      fifo_clr <= 1'b0; data_q <= '0; top_q <= '0; cbp_q <= '0;
      thr_lo <= '0; thr_hi <= '0;
    end else begin
      irq        <= 1'b0;
      work_start <= 1'b0;
      fifo_clr   <= 1'b0;
      if (srst) begin
        busy     <= 1'b0;
        cur_cmd  <= NO_CMD;
        top_q    <= '0;
        cbp_q    <= '0;
        fifo_clr <= 1'b1;
      end else if (cmd_go) begin
        if (dec.inline_op) begin
          busy    <= 1'b0;
          cur_cmd <= NO_CMD;
          irq     <= 1'b1;
          if (dec.flush) fifo_clr <= 1'b1;
          if (dec.thresh) begin
            thr_lo <= wr_data[THR_W-1:0];
            thr_hi <= wr_data[16 +: THR_W];
          end
        end else begin
          busy       <= 1'b1;
          cur_cmd    <= wr_data;
          work_start <= 1'b1;
        end
      end else if (busy && work_done) begin
        busy    <= 1'b0;
        cur_cmd <= NO_CMD;
        irq     <= 1'b1;
        data_q  <= work_data;
        top_q   <= work_top;
        cbp_q   <= work_cbp;
      end
    end
  end

  always_comb begin
    case (rofs)
      OFS_DATA: rd_data = data_q;
      OFS_CTRL: rd_data = {busy, 7'd0, mode, prec, scd, ecd, cbp_q, 8'(fifo_count)};
      OFS_BPTR: rd_data = {14'd0, fill_ptr, 8'(fifo_count), 1'b0, bp};
      OFS_TOP:  rd_data = top_q;
      default:  rd_data = '0;
    endcase
  end

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_we)); // R5
  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cur_cmd == NO_CMD)); // R6
  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && work_done && !wr_en) |=> (!busy && irq)); // R6
  AST_INLINE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && dec.inline_op) |=> (!busy && irq)); // R3
  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && work_done && !wr_en) |=> !irq); // R13
endmodule

// File: tb/mbdec_cmd_regs_tb.sv
`timescale 1ns/100ps
module mbdec_cmd_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        work_start, busy, irq, fifo_clr;
  logic [31:0] cur_cmd;
  logic        work_done = 1'b0;
  logic [31:0] work_data = '0, work_top = '0;
  logic [5:0]  work_cbp = '0;
  logic        ecd_set = 1'b0, scd_set = 1'b0, bp_adv_en = 1'b0;
  logic [6:0]  bp_adv_amt = '0;
  logic [3:0]  fifo_count = 4'd3;
  logic [1:0]  fill_ptr = 2'd0;
  logic [7:0]  thr_lo, thr_hi;
  logic [1:0]  prec;
  logic [5:0]  mode;

  int checks = 0, errors = 0;
  int irq_cnt = 0, start_cnt = 0, clr_cnt = 0;
  logic        probe = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mbdec_cmd_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .work_start(work_start), .cur_cmd(cur_cmd),
    .busy(busy), .irq(irq), .work_done(work_done), .work_data(work_data),
    .work_top(work_top), .work_cbp(work_cbp), .ecd_set(ecd_set), .scd_set(scd_set),
    .bp_adv_en(bp_adv_en), .bp_adv_amt(bp_adv_amt), .fifo_count(fifo_count),
    .fill_ptr(fill_ptr), .fifo_clr(fifo_clr), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .prec(prec), .mode(mode)
  );

  // monitor: pulse counters and scoreboard pop
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (work_start) start_cnt++;
    if (fifo_clr) clr_cnt++;
    if (probe && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s actual %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [15:0] a, input logic [31:0] d,
                       input logic dn, input logic st, input logic adv,
                       input logic [6:0] amt);
    @(posedge clk); #1;
    wr_en = we; wr_addr = a; wr_data = d; work_done = dn;
    ecd_set = st; scd_set = st; bp_adv_en = adv; bp_adv_amt = amt;
    @(posedge clk); #1;
    wr_en = 1'b0; work_done = 1'b0; ecd_set = 1'b0; scd_set = 1'b0; bp_adv_en = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, 1'b0, 1'b0, 7'd0);
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    probe = 1'b1;
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state
    rd_expect(16'h0010, 32'h0000_0003, "R10 reset ctrl");
    rd_expect(16'h0020, 32'h0000_0300, "R9 reset bptr");
    rd_expect(16'h0000, 32'h0, "reset data");
    chk(cur_cmd, 32'hFFFF_FFFF, "R6 reset cur_cmd");

    fifo_count = 4'd5; fill_ptr = 2'd2;
    wr(16'h0000, 32'h0000_0025);                      // flush, pointer 0x25
    rd_expect(16'h0020, 32'h0002_0525, "R9 R3 flush bptr");
    chk(busy, 1'b0, "R3 flush busy");
    chk(irq_cnt, 1, "R3 flush irq");
    chk(clr_cnt, 1, "R3 flush fifo_clr");

    wr(16'h0000, 32'h1000_0013);                      // intra decode, skip 0x13
    rd_expect(16'h0020, 32'h0002_0538, "R4 skip advance");
    rd_expect(16'h0010, 32'h8000_0005, "R5 busy in ctrl");
    chk(cur_cmd, 32'h1000_0013, "R5 cur_cmd");
    chk(start_cnt, 1, "R5 start");

    work_data = 32'hDEAD_0001; work_top = 32'h0000_BEEF; work_cbp = 6'h2A;
    drive(1'b0, 16'h0, 32'h0, 1'b1, 1'b0, 1'b0, 7'd0);
    chk(busy, 1'b0, "R6 done busy");
    chk(cur_cmd, 32'hFFFF_FFFF, "R6 done cur_cmd");
    chk(irq_cnt, 2, "R6 done irq single pulse");
    rd_expect(16'h0000, 32'hDEAD_0001, "R6 data");
    rd_expect(16'h0030, 32'h0000_BEEF, "R6 top");
    rd_expect(16'h0010, 32'h0000_2A05, "R6 R10 cbp ctrl");

    drive(1'b0, 16'h0, 32'h0, 1'b1, 1'b0, 1'b0, 7'd0); // idle done
    chk(irq_cnt, 2, "R13 idle done irq");

    wr(16'h0000, 32'h3000_003F);                      // vld skip 63
    wr(16'h0000, 32'h4000_003F);                      // fld override, wraps
    chk(cur_cmd, 32'h4000_003F, "R12 override cur_cmd");
    chk(busy, 1'b1, "R12 override busy");
    rd_expect(16'h0020, 32'h0002_0536, "R4 wrap modulo 128");

    work_top = 32'h0000_1111;
    drive(1'b1, 16'h0000, 32'h6000_0011, 1'b1, 1'b0, 1'b0, 7'd0); // write + done
    chk(cur_cmd, 32'h6000_0011, "R12 collide cur_cmd");
    chk(busy, 1'b1, "R12 collide busy");
    chk(irq_cnt, 2, "R12 collide irq");
    rd_expect(16'h0030, 32'h0000_BEEF, "R12 collide top");
    rd_expect(16'h0020, 32'h0002_0536, "R4 no skip opcode 6");
    chk(start_cnt, 4, "R5 start count");

    work_data = 32'h1234_5678; work_top = 32'h0000_CAFE;
    drive(1'b0, 16'h0, 32'h0, 1'b1, 1'b0, 1'b0, 7'd0);
    chk(irq_cnt, 3, "R6 second done irq");
    rd_expect(16'h0030, 32'h0000_CAFE, "R6 top second");

    drive(1'b0, 16'h0, 32'h0, 1'b0, 1'b1, 1'b0, 7'd0);  // set both status
    rd_expect(16'h0010, 32'h0000_EA05, "R2 status set");
    drive(1'b1, 16'h0000, 32'h9044_0012, 1'b0, 1'b1, 1'b0, 7'd0); // thresh + set
    rd_expect(16'h0010, 32'h0000_2A05, "R2 clear beats set");
    chk(thr_lo, 8'h12, "R3 thr_lo");
    chk(thr_hi, 8'h44, "R3 thr_hi");
    chk(irq_cnt, 4, "R3 thresh irq");
    chk(busy, 1'b0, "R3 thresh busy");

    wr(16'h0010, 32'h0057_0000);                      // mode 0x15, prec 3
    rd_expect(16'h0010, 32'h0055_2A05, "R7 prec 3 forced");
    chk(prec, 2'd1, "R7 prec port");
    chk(mode, 6'h15, "R7 mode port");
    wr(16'h0010, 32'h0002_0000);
    rd_expect(16'h0010, 32'h0002_2A05, "R7 prec 2 kept");

    drive(1'b0, 16'h0, 32'h0, 1'b0, 1'b1, 1'b0, 7'd0);
    wr(16'h0000, 32'hB000_0005);                      // undefined opcode
    rd_expect(16'h0010, 32'h0002_EA05, "R11 ignored ctrl");
    rd_expect(16'h0020, 32'h0002_0536, "R11 ignored bptr");
    chk(irq_cnt, 4, "R11 ignored irq");

    wr(16'h0000, 32'h2000_0002);                      // block decode
    wr(16'h0010, 32'h4002_0000);                      // soft reset
    chk(busy, 1'b0, "R8 busy");
    chk(cur_cmd, 32'hFFFF_FFFF, "R8 cur_cmd");
    chk(clr_cnt, 2, "R8 fifo_clr");
    rd_expect(16'h0010, 32'h0002_0005, "R8 ctrl");
    rd_expect(16'h0020, 32'h0002_0500, "R8 bptr");
    rd_expect(16'h0030, 32'h0, "R8 top");
    drive(1'b0, 16'h0, 32'h0, 1'b1, 1'b0, 1'b0, 7'd0);
    chk(irq_cnt, 4, "R13 done after soft reset");

    wr(16'h0100, 32'h0000_0011);                      // alias of command offset
    rd_expect(16'h0320, 32'h0002_0511, "R1 alias write and read");
    rd_expect(16'hAB10, 32'h0002_0005, "R1 alias ctrl");

    drive(1'b0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b1, 7'h70);
    rd_expect(16'h0020, 32'h0002_0501, "R4 worker advance");

    fifo_count = 4'd7;
    rd_expect(16'h0010, 32'h0002_0007, "R10 live count");

    @(posedge clk); #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule